// File: doc/BRIEF.md
# Packet Statistics Control Register File

This block is a memory-mapped control and statistics register file that sits beside a packet-forwarding pipeline. Software reaches it through an AXI-Lite slave port. It holds two read-only identification words and a reset control word. It also holds two test registers: one reads back the negation of what was written, the other reads back the written value plus a fixed offset. Four event counters count single-cycle increment pulses from the pipeline: packets received, packets sent, lookup hits and lookup misses.

A write to the reset control word produces one-cycle internal pulses. One pulse clears the four counters and another returns the test registers to zero. A third pulse leaves the block on `tbl_clear` so that a neighbouring lookup table can flush itself. Each read and each write completes with an OKAY response. Addresses outside the map are harmless.

Top module: `pktstat_regfile`

## Requirements
- R1: Word offset 0x0 reads the ID_VALUE parameter and offset 0x4 reads VERSION_VALUE. Writes to these two words and to the counter words (offsets 0x14 to 0x20) leave every readback unchanged.
- R2: The bits of `evt_inc` map to counters in this order: bit 0 to offset 0x14 (received), bit 1 to 0x18 (sent), bit 2 to 0x1C (hit) and bit 3 to 0x20 (miss). Each counter adds one on every clock cycle in which its bit is high, wraps modulo 2^CNT_W, and reads back zero-extended to DATA_W.
- R3: Writing the reset word (offset 0x8) with bit 0 set clears all four counters one cycle after the write is accepted. An increment that coincides with the clear is lost.
- R4: Writing the reset word with bit 4 set returns the stored FLIP and DEBUG values to zero.
- R5: Writing the reset word with bit 8 set raises `tbl_clear` for exactly one cycle. All reset bits clear themselves, and the reset word always reads zero.
- R6: Offset 0xC reads the two's-complement negation of the value last written there.
- R7: Offset 0x10 reads the value last written there plus DEBUG_OFFSET, modulo 2^DATA_W.
- R8: An address below BASE_ADDR, above HIGH_ADDR, or past offset 0x20 reads zero. A write to such an address changes nothing. Both complete with response code 0 (OKAY).
- R9: The write address and write data may arrive together or in either order. `bvalid` rises after both are taken and stays high until `bready` is high. No new write is accepted while a response is pending.
- R10: After an address is accepted, `rvalid` stays high and `rdata` stays stable until `rready` is high. `arready` is low while a read response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_axil_awaddr | input | ADDR_W | Write address |
| s_axil_awvalid | input | 1 | Write address valid |
| s_axil_awready | output | 1 | Write address ready |
| s_axil_wdata | input | DATA_W | Write data |
| s_axil_wvalid | input | 1 | Write data valid |
| s_axil_wready | output | 1 | Write data ready |
| s_axil_bresp | output | 2 | Write response code |
| s_axil_bvalid | output | 1 | Write response valid |
| s_axil_bready | input | 1 | Write response ready |
| s_axil_araddr | input | ADDR_W | Read address |
| s_axil_arvalid | input | 1 | Read address valid |
| s_axil_arready | output | 1 | Read address ready |
| s_axil_rdata | output | DATA_W | Read data |
| s_axil_rresp | output | 2 | Read response code |
| s_axil_rvalid | output | 1 | Read data valid |
| s_axil_rready | input | 1 | Read data ready |
| evt_inc | input | 4 | Increment pulses: received, sent, hit, miss |
| tbl_clear | output | 1 | One-cycle table-clear request |

## Verification
The assertions check on every cycle that handshake responses are held while the manager stalls, and that no write starts while a response is pending. They also check that a counter clear beats a same-cycle increment, that an idle counter holds its value, that `tbl_clear` never lasts two cycles, and that the register-restore pulse zeroes both test registers. The bench's scenarios show what the assertions cannot see: the address decode across the whole map with a non-zero base, readback arithmetic for the negating and offset registers, counter wrap with a narrow counter, that read-only and out-of-map writes have no effect, and both arrival orders of address and data.

// File: rtl/pktstat_pkg.sv
package pktstat_pkg;

  localparam int unsigned NUM_EVT   = 4;
  localparam int unsigned LAST_WORD = 8;

  // reset-word bit positions (software-visible)
  localparam int unsigned RST_CNT_BIT = 0;
  localparam int unsigned RST_REG_BIT = 4;
  localparam int unsigned RST_TBL_BIT = 8;

  // word index within the map; order fixes the offsets
  typedef enum logic [3:0] {
    SEL_ID   = 4'd0,
    SEL_VER  = 4'd1,
    SEL_RST  = 4'd2,
    SEL_FLIP = 4'd3,
    SEL_DBG  = 4'd4,
    SEL_CIN  = 4'd5,
    SEL_COUT = 4'd6,
    SEL_HIT  = 4'd7,
    SEL_MISS = 4'd8
  } reg_sel_e;

  typedef struct packed {
    logic     hit;
    reg_sel_e sel;
  } dec_t;

endpackage

// File: rtl/pktstat_counter.sv
module pktstat_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);

  always_ff @(posedge clk) begin
    if (rst || clr)
      count <= '0;
    else if (inc)
      count <= count + 1'b1;
  end

  assert_clear_wins_R3: assert property (@(posedge clk) disable iff (rst)
    clr |=> count == '0);

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!clr && !inc) |=> $stable(count));

endmodule

// File: rtl/pktstat_axil_wr.sv
module pktstat_axil_wr #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              awvalid,
  output logic              awready,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wvalid,
  output logic              wready,
  output logic              bvalid,
  input  logic              bready,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);

  logic              aw_have, w_have;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              aw_fire, w_fire;

  assign awready = !aw_have && !bvalid;
  assign wready  = !w_have && !bvalid;
  assign aw_fire = awvalid && awready;
  assign w_fire  = wvalid && wready;

  assign wr_en   = (aw_have || aw_fire) && (w_have || w_fire);
  assign wr_addr = aw_have ? addr_q : awaddr;
  assign wr_data = w_have ? data_q : wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      aw_have <= 1'b0;
      w_have  <= 1'b0;
      bvalid  <= 1'b0;
    end else begin
      if (wr_en) begin
        aw_have <= 1'b0;
        w_have  <= 1'b0;
        bvalid  <= 1'b1;
      end else begin
        if (aw_fire) aw_have <= 1'b1;
        if (w_fire)  w_have  <= 1'b1;
        if (bvalid && bready) bvalid <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (aw_fire) addr_q <= awaddr;
    if (w_fire)  data_q <= wdata;
  end

  assert_bresp_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (bvalid && !bready) |=> bvalid);

  assert_no_write_while_pending_R9: assert property (@(posedge clk) disable iff (rst)
    bvalid |-> !wr_en);

endmodule

// File: rtl/pktstat_regfile.sv
module pktstat_regfile #(
  parameter int unsigned        ADDR_W        = 32,
  parameter int unsigned        DATA_W        = 32,
  parameter int unsigned        CNT_W         = 32,
  parameter logic [ADDR_W-1:0]  BASE_ADDR     = '0,
  parameter logic [ADDR_W-1:0]  HIGH_ADDR     = 'h3F,
  parameter logic [DATA_W-1:0]  ID_VALUE      = 'h5157_0001,
  parameter logic [DATA_W-1:0]  VERSION_VALUE = 'h0001_0000,
  parameter logic [DATA_W-1:0]  DEBUG_OFFSET  = 'h0000_1000
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [ADDR_W-1:0]            s_axil_awaddr,
  input  logic                         s_axil_awvalid,
  output logic                         s_axil_awready,
  input  logic [DATA_W-1:0]            s_axil_wdata,
  input  logic                         s_axil_wvalid,
  output logic                         s_axil_wready,
  output logic [1:0]                   s_axil_bresp,
  output logic                         s_axil_bvalid,
  input  logic                         s_axil_bready,
  input  logic [ADDR_W-1:0]            s_axil_araddr,
  input  logic                         s_axil_arvalid,
  output logic                         s_axil_arready,
  output logic [DATA_W-1:0]            s_axil_rdata,
  output logic [1:0]                   s_axil_rresp,
  output logic                         s_axil_rvalid,
  input  logic                         s_axil_rready,
  input  logic [pktstat_pkg::NUM_EVT-1:0] evt_inc,
  output logic                         tbl_clear
);
  import pktstat_pkg::*;

  localparam logic [ADDR_W-1:0] LAST_W = ADDR_W'(LAST_WORD);

  function automatic dec_t decode(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] off, word;
    dec_t d;
    off   = a - BASE_ADDR;
    word  = off >> 2;
    d.hit = (a >= BASE_ADDR) && (a <= HIGH_ADDR) && (word <= LAST_W);
    d.sel = reg_sel_e'(word[3:0]);
    return d;
  endfunction

  // write channel
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  dec_t              wsel;

  pktstat_axil_wr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
    .clk     (clk),
    .rst     (rst),
    .awaddr  (s_axil_awaddr),
    .awvalid (s_axil_awvalid),
    .awready (s_axil_awready),
    .wdata   (s_axil_wdata),
    .wvalid  (s_axil_wvalid),
    .wready  (s_axil_wready),
    .bvalid  (s_axil_bvalid),
    .bready  (s_axil_bready),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data)
  );

  assign s_axil_bresp = 2'b00;
  assign wsel = decode(wr_addr);

  logic              rst_wr;
  logic              clr_cnt_q, clr_reg_q, tbl_clr_q;
  logic [DATA_W-1:0] flip_q, dbg_q;

  assign rst_wr = wr_en && wsel.hit && (wsel.sel == SEL_RST);

  always_ff @(posedge clk) begin
    if (rst) begin
      clr_cnt_q <= 1'b0;
      clr_reg_q <= 1'b0;
      tbl_clr_q <= 1'b0;
      flip_q    <= '0;
      dbg_q     <= '0;
    end else begin
      clr_cnt_q <= rst_wr && wr_data[RST_CNT_BIT];
      clr_reg_q <= rst_wr && wr_data[RST_REG_BIT];
      tbl_clr_q <= rst_wr && wr_data[RST_TBL_BIT];
      if (clr_reg_q) begin
        flip_q <= '0;
        dbg_q  <= '0;
      end else if (wr_en && wsel.hit) begin
        if (wsel.sel == SEL_FLIP) flip_q <= wr_data;
        if (wsel.sel == SEL_DBG)  dbg_q  <= wr_data;
      end
    end
  end

  assign tbl_clear = tbl_clr_q;

  // event counters
  logic [CNT_W-1:0] cnt [NUM_EVT];

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_cnt
    pktstat_counter #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .clr   (clr_cnt_q),
      .inc   (evt_inc[i]),
      .count (cnt[i])
    );
  end

  // read channel
  dec_t              rsel;
  logic [DATA_W-1:0] rd_mux;
  logic              ar_fire;

  assign rsel           = decode(s_axil_araddr);
  assign s_axil_arready = !s_axil_rvalid;
  assign ar_fire        = s_axil_arvalid && s_axil_arready;
  assign s_axil_rresp   = 2'b00;

  always_comb begin
    rd_mux = '0;
    if (rsel.hit) begin
      case (rsel.sel)
        SEL_ID:   rd_mux = ID_VALUE;
        SEL_VER:  rd_mux = VERSION_VALUE;
        SEL_FLIP: rd_mux = -flip_q;
        SEL_DBG:  rd_mux = dbg_q + DEBUG_OFFSET;
        SEL_CIN:  rd_mux = DATA_W'(cnt[0]);
        SEL_COUT: rd_mux = DATA_W'(cnt[1]);
        SEL_HIT:  rd_mux = DATA_W'(cnt[2]);
        SEL_MISS: rd_mux = DATA_W'(cnt[3]);
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s_axil_rvalid <= 1'b0;
      s_axil_rdata  <= '0;
    end else if (ar_fire) begin
      s_axil_rvalid <= 1'b1;
      s_axil_rdata  <= rd_mux;
    end else if (s_axil_rvalid && s_axil_rready) begin
      s_axil_rvalid <= 1'b0;
    end
  end

  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (s_axil_rvalid && !s_axil_rready) |=> (s_axil_rvalid && $stable(s_axil_rdata)));

  assert_tbl_pulse_single_R5: assert property (@(posedge clk) disable iff (rst)
    tbl_clear |=> !tbl_clear);

  assert_regs_restored_R4: assert property (@(posedge clk) disable iff (rst)
    clr_reg_q |=> (flip_q == '0 && dbg_q == '0));

endmodule

// File: tb/tb_pktstat_regfile.sv
module tb_pktstat_regfile;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 8;
  localparam logic [31:0] BASE = 32'h100;
  localparam logic [31:0] HIGH = 32'h13F;
  localparam logic [31:0] IDV  = 32'hC0DE_0042;
  localparam logic [31:0] VERV = 32'h0001_0003;
  localparam logic [31:0] DOFF = 32'h1000_0001;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] awaddr = '0, wdata = '0, araddr = '0;
  logic        awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
  logic        awready, wready, bvalid, arready, rvalid, tbl_clear;
  logic [1:0]  bresp, rresp;
  logic [31:0] rdata;
  logic [3:0]  evt_inc = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pktstat_regfile #(
    .ADDR_W(32), .DATA_W(32), .CNT_W(CNT_W), .BASE_ADDR(BASE), .HIGH_ADDR(HIGH),
    .ID_VALUE(IDV), .VERSION_VALUE(VERV), .DEBUG_OFFSET(DOFF)
  ) dut (
    .clk(clk), .rst(rst),
    .s_axil_awaddr(awaddr), .s_axil_awvalid(awvalid), .s_axil_awready(awready),
    .s_axil_wdata(wdata), .s_axil_wvalid(wvalid), .s_axil_wready(wready),
    .s_axil_bresp(bresp), .s_axil_bvalid(bvalid), .s_axil_bready(bready),
    .s_axil_araddr(araddr), .s_axil_arvalid(arvalid), .s_axil_arready(arready),
    .s_axil_rdata(rdata), .s_axil_rresp(rresp), .s_axil_rvalid(rvalid),
    .s_axil_rready(rready), .evt_inc(evt_inc), .tbl_clear(tbl_clear)
  );

  int n_chk = 0, n_bad = 0;
  int tbl_pulses = 0, tbl_run = 0, tbl_maxrun = 0;
  bit finished = 0;
  int mode_rr = 0;

  // reference model
  logic [31:0] flip_m = '0, dbg_m = '0;
  int cnt_m [4] = '{0, 0, 0, 0};

  always @(posedge clk) begin
    if (tbl_clear) begin
      tbl_pulses++;
      tbl_run++;
      if (tbl_run > tbl_maxrun) tbl_maxrun = tbl_run;
    end else tbl_run = 0;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [31:0] a);
    logic [31:0] w;
    if (a < BASE || a > HIGH) return 32'h0;
    w = (a - BASE) >> 2;
    case (w)
      0: return IDV;
      1: return VERV;
      2: return 32'h0;
      3: return -flip_m;
      4: return dbg_m + DOFF;
      5, 6, 7, 8: return 32'(cnt_m[w-5]);
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [31:0] a);
    logic [31:0] w;
    if (a < BASE || a > HIGH) return "R8";
    w = (a - BASE) >> 2;
    case (w)
      0, 1: return "R1";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      5, 6, 7, 8: return "R2";
      default: return "R8";
    endcase
  endfunction

  task automatic axil_write(input logic [31:0] a, input logic [31:0] d,
                            input bit pulse_after);
    bit aw_done = 0, w_done = 0, ac, wc;
    int cyc = 0;
    int mode = mode_rr % 3;
    mode_rr++;
    @(negedge clk);
    awaddr = a; wdata = d;
    if (mode != 2) awvalid = 1;
    if (mode != 1) wvalid = 1;
    while (!(aw_done && w_done)) begin
      ac = awvalid && awready;
      wc = wvalid && wready;
      @(negedge clk);
      if (ac) begin awvalid = 0; aw_done = 1; end
      if (wc) begin wvalid = 0; w_done = 1; end
      cyc++;
      if (cyc == 2) begin
        if (mode == 1 && !w_done) wvalid = 1;
        if (mode == 2 && !aw_done) awvalid = 1;
      end
      if (cyc == 1 && mode != 0) check("R9 one channel alone gives no response", {31'b0, bvalid}, 32'h0);
    end
    check("R9 response after both channels", {31'b0, bvalid}, 32'h1);
    check("R8 bresp OKAY", {30'b0, bresp}, 32'h0);
    if (pulse_after) evt_inc = 4'hF;
    repeat (2) begin
      @(negedge clk);
      evt_inc = 4'h0;
      check("R9 bvalid held without bready", {31'b0, bvalid}, 32'h1);
      check("R9 no accept while pending", {30'b0, awready, wready}, 32'h0);
    end
    bready = 1;
    @(negedge clk);
    bready = 0;
    check("R9 bvalid drops after bready", {31'b0, bvalid}, 32'h0);
  endtask

  task automatic axil_read(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    araddr = a; arvalid = 1;
    check("R10 arready idle", {31'b0, arready}, 32'h1);
    @(negedge clk);
    arvalid = 0;
    check("R10 rvalid after accept", {31'b0, rvalid}, 32'h1);
    check("R8 rresp OKAY", {30'b0, rresp}, 32'h0);
    d = rdata;
    @(negedge clk);
    check("R10 rvalid held", {31'b0, rvalid}, 32'h1);
    check("R10 rdata stable", rdata, d);
    check("R10 arready low while pending", {31'b0, arready}, 32'h0);
    rready = 1;
    @(negedge clk);
    rready = 0;
    check("R10 rvalid drops", {31'b0, rvalid}, 32'h0);
  endtask

  task automatic sweep();
    logic [31:0] d;
    for (logic [31:0] a = 32'hF0; a <= 32'h14C; a += 4) begin
      axil_read(a, d);
      check(tag_of(a), d, model(a));
    end
  endtask

  task automatic pulse(input logic [3:0] m, input int n);
    @(negedge clk);
    evt_inc = m;
    repeat (n) @(negedge clk);
    evt_inc = 4'h0;
    for (int i = 0; i < 4; i++)
      if (m[i]) cnt_m[i] = (cnt_m[i] + n) % (1 << CNT_W);
  endtask

  task automatic bump_model();
    for (int i = 0; i < 4; i++) cnt_m[i] = (cnt_m[i] + 1) % (1 << CNT_W);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] vals [5] = '{32'h0, 32'h1, 32'h8000_0000, 32'hFFFF_FFFF, 32'h1234_5678};
    int p0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // reset state
    check("R9 reset bvalid", {31'b0, bvalid}, 32'h0);
    check("R10 reset rvalid", {31'b0, rvalid}, 32'h0);
    check("R5 reset tbl_clear", {31'b0, tbl_clear}, 32'h0);
    check("R9 reset ready", {30'b0, awready, wready}, 32'h3);
    sweep();

    // R2: distinct patterns per counter
    pulse(4'b0001, 3);
    pulse(4'b0010, 5);
    pulse(4'b0100, 7);
    pulse(4'b1000, 2);
    pulse(4'b1111, 4);
    pulse(4'b0101, 1);
    sweep();

    // R1: read-only words and counters ignore writes
    for (logic [31:0] a = BASE; a <= BASE + 32'h20; a += 4)
      if (a != BASE + 8 && a != BASE + 12 && a != BASE + 16)
        axil_write(a, 32'hFFFF_FFFF, 0);
    sweep();

    // R8: writes outside the map
    axil_write(32'h0F0, 32'h0000_0111, 0);
    axil_write(32'h0FC, 32'h0000_0111, 0);
    axil_write(BASE + 32'h24, 32'h0000_0111, 0);
    axil_write(BASE + 32'h3C, 32'h0000_0111, 0);
    axil_write(HIGH + 1, 32'h0000_0111, 0);
    check("R8 no table pulse from unmapped write", 32'(tbl_pulses), 32'h0);
    sweep();

    // R6 / R7
    foreach (vals[i]) begin
      axil_write(BASE + 12, vals[i], 0);
      flip_m = vals[i];
      axil_read(BASE + 12, d);
      check("R6 flip negation", d, -vals[i]);
      axil_write(BASE + 16, vals[i], 0);
      dbg_m = vals[i];
      axil_read(BASE + 16, d);
      check("R7 debug offset", d, vals[i] + DOFF);
    end
    axil_write(BASE + 12, 32'h0000_00AA, 0); flip_m = 32'hAA;
    axil_write(BASE + 16, 32'h0000_0055, 0); dbg_m = 32'h55;
    sweep();

    // R4: register restore only
    axil_write(BASE + 8, 32'h0000_0010, 0);
    flip_m = 0; dbg_m = 0;
    check("R4 no table pulse", 32'(tbl_pulses), 32'h0);
    sweep();

    // R2: wrap with narrow counter
    pulse(4'b0001, (1 << CNT_W) + 3);
    pulse(4'b1000, (1 << CNT_W) - 1);
    sweep();

    // control: coincident pulse counts when no clear is requested
    axil_write(BASE + 12, 32'h0000_0007, 1);
    flip_m = 32'h7;
    bump_model();
    sweep();

    // R3: counter clear wins over coincident increment
    axil_write(BASE + 8, 32'h0000_0001, 1);
    for (int i = 0; i < 4; i++) cnt_m[i] = 0;
    check("R3 flip kept by counter clear", model(BASE + 12), -32'h7);
    sweep();

    // R5: table pulse, one cycle, others untouched
    pulse(4'b0110, 9);
    p0 = tbl_pulses;
    axil_write(BASE + 8, 32'h0000_0100, 0);
    check("R5 one table pulse", 32'(tbl_pulses - p0), 32'h1);
    check("R5 pulse length one", 32'(tbl_maxrun), 32'h1);
    axil_read(BASE + 8, d);
    check("R5 reset word reads zero", d, 32'h0);
    sweep();

    // all reset bits at once
    axil_write(BASE + 16, 32'h0000_0321, 0); dbg_m = 32'h321;
    p0 = tbl_pulses;
    axil_write(BASE + 8, 32'h0000_0111, 0);
    for (int i = 0; i < 4; i++) cnt_m[i] = 0;
    flip_m = 0; dbg_m = 0;
    check("R5 combined pulse", 32'(tbl_pulses - p0), 32'h1);
    check("R5 combined pulse length", 32'(tbl_maxrun), 32'h1);
    sweep();

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule